// File: doc/BRIEF.md
# Read Burst Sequencer with Burst Stop

This block is the device-side read sequencer of a double-data-rate memory. Decoded commands are sampled on the rising clock edge. A read returns a burst of beat pairs after the programmed CAS latency. Each clock carries two beats: one for the rising half and one for the falling half. The block drives a single output enable for the data pins. It also drives one output enable per strobe pin, and every strobe enable follows the data enable exactly.

A burst stop command shortens a plain read. The bus goes quiet the same number of clocks after the stop as the CAS latency. A stop that arrives during a write burst, or during a read with autoprecharge, is not acted on. Instead it raises a one-cycle error flag.

Read data comes from a built-in pattern over an incrementing column counter, so the beats that reach the bus before a cut-off can be identified. The array, bank timing and the pad drivers are outside this block.

Top module: `ddr_rd_burst_ctl`

## Requirements
- R1: `cmd` is decoded only at rising clock edges, with these codes: 0 no-op, 1 read, 2 read with autoprecharge, 3 write, 4 burst stop. Codes 5 to 7 act as no-op, and a value that is present only between two rising edges has no effect.
- R2: A read (code 1 or 2) sampled at edge k raises `data_oe` from edge k+CL for one clock per beat pair. CL is 2 when `cfg_cl` is 0 and 3 when it is 1.
- R3: `cfg_bl` selects the burst as follows: 0 gives 2 beats (1 pair), 1 gives 4 beats (2 pairs), and 2 or 3 give 8 beats (4 pairs).
- R4: Pair i of a read to column c has pair address p = (c[7:1] + i) mod 128. With b = {p,0} on the rising beat and b = {p,1} on the falling beat, each beat carries {b XOR 8'hA5, b}.
- R5: While `data_oe` is low, both data outputs are zero.
- R6: A burst stop sampled d edges after a plain read, with 1 ≤ d ≤ pairs, limits that burst to d pairs. The enables drop at the stop edge plus CL.
- R7: A burst stop sampled within `pairs` edges after a write is ignored. `stop_err` is high for the one clock following that edge.
- R8: A burst stop sampled within `pairs` edges after a read with autoprecharge is ignored, so the burst completes. `stop_err` is high for the one clock following that edge.
- R9: A burst stop with no read or write in progress has no effect. `stop_err` is low whenever R7 and R8 do not apply.
- R10: A read that arrives while a burst is still being issued replaces the old burst. Every slot from the new edge plus CL onward carries the new burst.
- R11: A write sampled at edge k stops any read still being issued. No pair is driven from edge k+CL onward.
- R12: Every bit of `strobe_oe` equals `data_oe` at all times.
- R13: During reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command code |
| col_addr | input | COL_W | Starting column of a read |
| cfg_bl | input | 2 | Burst length select |
| cfg_cl | input | 1 | CAS latency select (0: 2, 1: 3) |
| rd_data_rise | output | 2*COL_W | Beat driven in the rising half |
| rd_data_fall | output | 2*COL_W | Beat driven in the falling half |
| data_oe | output | 1 | Output enable for all data pins |
| strobe_oe | output | DQS_N | Output enable for each strobe pin |
| stop_err | output | 1 | One-cycle flag for an illegal burst stop |

## Verification
The latency properties assume that `cfg_cl` and `cfg_bl` hold still while any burst is in flight. The stimulus therefore changes configuration only after a run of at least a dozen no-op clocks has emptied the pipeline. Commands are driven on the falling edge, so that every rising edge sees a settled code. The only exception is one deliberate pulse that lives only in the high phase of the clock.

// File: rtl/ddr_rd_burst_ctl.sv
module ddr_rd_burst_ctl #(
  parameter int COL_W = 8,
  parameter int DQS_N = 2,
  parameter logic [COL_W-1:0] PAT_XOR = 'hA5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cmd,
  input  logic [COL_W-1:0]   col_addr,
  input  logic [1:0]         cfg_bl,
  input  logic               cfg_cl,
  output logic [2*COL_W-1:0] rd_data_rise,
  output logic [2*COL_W-1:0] rd_data_fall,
  output logic               data_oe,
  output logic [DQS_N-1:0]   strobe_oe,
  output logic               stop_err
);
  localparam int PW = COL_W - 1;
  localparam int LAT_MAX = 3;
  localparam logic [2:0] CMD_RD = 3'd1, CMD_RDA = 3'd2, CMD_WR = 3'd3, CMD_STOP = 3'd4;

  logic [2:0]    pairs;
  logic          iss_v, iss_ap;
  logic [2:0]    iss_left, wr_left;
  logic [PW-1:0] iss_pa;
  logic [LAT_MAX:1] pipe_v;
  logic [PW-1:0] pipe_pa [LAT_MAX:1];
  logic [PW-1:0] out_pa;
  logic [COL_W-1:0] b_rise, b_fall;

  assign pairs = (cfg_bl == 2'd0) ? 3'd1 : (cfg_bl == 2'd1) ? 3'd2 : 3'd4;

  wire is_rd    = (cmd == CMD_RD) || (cmd == CMD_RDA);
  wire is_stop  = (cmd == CMD_STOP);
  wire wr_busy  = (wr_left != 3'd0);
  wire stop_bad = is_stop && (wr_busy || (iss_v && iss_ap));
  wire stop_cut = is_stop && iss_v && !iss_ap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_v    <= 1'b0;
      iss_ap   <= 1'b0;
      iss_left <= '0;
      iss_pa   <= '0;
      wr_left  <= '0;
      stop_err <= 1'b0;
      pipe_v   <= '0;
      for (int i = 1; i <= LAT_MAX; i++) pipe_pa[i] <= '0;
    end else begin
      stop_err <= stop_bad;
      if (is_rd) begin
        iss_v    <= 1'b1;
        iss_ap   <= (cmd == CMD_RDA);
        iss_pa   <= col_addr[COL_W-1:1];
        iss_left <= pairs - 3'd1;
        wr_left  <= '0;
      end else if (cmd == CMD_WR) begin
        iss_v   <= 1'b0;
        wr_left <= pairs;
      end else begin
        if (iss_v) begin
          if (stop_cut || iss_left == 3'd0) iss_v <= 1'b0;
          else begin
            iss_pa   <= iss_pa + 1'b1;
            iss_left <= iss_left - 3'd1;
          end
        end
        if (wr_busy) wr_left <= wr_left - 3'd1;
      end
      pipe_v[1]  <= iss_v;
      pipe_pa[1] <= iss_pa;
      for (int i = 2; i <= LAT_MAX; i++) begin
        pipe_v[i]  <= pipe_v[i-1];
        pipe_pa[i] <= pipe_pa[i-1];
      end
    end
  end

  assign data_oe      = cfg_cl ? pipe_v[3] : pipe_v[2];
  assign out_pa       = cfg_cl ? pipe_pa[3] : pipe_pa[2];
  assign strobe_oe    = {DQS_N{data_oe}};
  assign b_rise       = {out_pa, 1'b0};
  assign b_fall       = {out_pa, 1'b1};
  assign rd_data_rise = data_oe ? {b_rise ^ PAT_XOR, b_rise} : '0;
  assign rd_data_fall = data_oe ? {b_fall ^ PAT_XOR, b_fall} : '0;
endmodule

// File: rtl/ddr_rd_burst_ctl_chk.sv
module ddr_rd_burst_ctl_chk #(
  parameter int COL_W = 8,
  parameter int DQS_N = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cmd,
  input logic               cfg_cl,
  input logic [2*COL_W-1:0] rd_data_rise,
  input logic [2*COL_W-1:0] rd_data_fall,
  input logic               data_oe,
  input logic [DQS_N-1:0]   strobe_oe,
  input logic               stop_err
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;

  // R5
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (rd_data_rise == '0 && rd_data_fall == '0));

  // R12
  strobe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe ? (&strobe_oe) : (strobe_oe == '0));

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && stop_err) |-> ($past(cmd) == 3'd4));

  // R2
  rd_lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && !cfg_cl && ($past(cmd, 3) == 3'd1 || $past(cmd, 3) == 3'd2)) |-> data_oe);

  // R2
  rd_lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && cfg_cl && ($past(cmd, 4) == 3'd1 || $past(cmd, 4) == 3'd2)) |-> data_oe);

  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && !cfg_cl && $past(cmd, 3) == 3'd3) |-> !data_oe);
endmodule

bind ddr_rd_burst_ctl ddr_rd_burst_ctl_chk #(.COL_W(COL_W), .DQS_N(DQS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_cl(cfg_cl),
  .rd_data_rise(rd_data_rise), .rd_data_fall(rd_data_fall),
  .data_oe(data_oe), .strobe_oe(strobe_oe), .stop_err(stop_err)
);

// File: tb/ddr_rd_burst_ctl_test.sv
`timescale 1ns/1ps
module ddr_rd_burst_ctl_test;
  localparam int SLOTS = 8192;
  localparam int DQS_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] col_addr = 8'd0;
  logic [1:0] cfg_bl = 2'd0;
  logic cfg_cl = 1'b0;
  logic [15:0] rd_data_rise, rd_data_fall;
  logic data_oe, stop_err;
  logic [DQS_N-1:0] strobe_oe;

  ddr_rd_burst_ctl #(.COL_W(8), .DQS_N(DQS_N)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col_addr(col_addr),
    .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .rd_data_rise(rd_data_rise), .rd_data_fall(rd_data_fall),
    .data_oe(data_oe), .strobe_oe(strobe_oe), .stop_err(stop_err)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int e = 0, np = 1, cl = 2, last_kind = 0, last_e = -100;
  bit exp_v [SLOTS];
  bit exp_err [SLOTS];
  logic [6:0] exp_pa [SLOTS];
  string exp_tag [SLOTS];
  string err_tag [SLOTS];

  function automatic logic [15:0] pat(logic [7:0] b);
    return {b ^ 8'hA5, b};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, e, act, expv);
    end
  endtask

  task automatic check_now();
    chk(exp_tag[e], 64'(data_oe), 64'(exp_v[e]));
    chk("R12", 64'(strobe_oe), exp_v[e] ? 64'({DQS_N{1'b1}}) : 64'd0);
    if (exp_v[e]) begin
      chk("R4", 64'(rd_data_rise), 64'(pat({exp_pa[e], 1'b0})));
      chk("R4", 64'(rd_data_fall), 64'(pat({exp_pa[e], 1'b1})));
    end else begin
      chk("R5", 64'(rd_data_rise), 64'd0);
      chk("R5", 64'(rd_data_fall), 64'd0);
    end
    chk(err_tag[e], 64'(stop_err), 64'(exp_err[e]));
  endtask

  task automatic clear_from(int s0, string tag);
    for (int s = s0; s < s0 + 8; s++)
      if (exp_v[s]) begin
        exp_v[s] = 1'b0;
        exp_tag[s] = tag;
      end
  endtask

  task automatic predict(int k, logic [2:0] c, logic [7:0] a);
    int d;
    case (c)
      3'd1, 3'd2: begin
        clear_from(k + cl, "R10");
        for (int i = 0; i < np; i++) begin
          exp_v[k+cl+i] = 1'b1;
          exp_pa[k+cl+i] = a[7:1] + 7'(i);
          exp_tag[k+cl+i] = "R2 R3";
        end
        last_kind = int'(c);
        last_e = k;
      end
      3'd3: begin
        clear_from(k + cl, "R11");
        last_kind = 3;
        last_e = k;
      end
      3'd4: begin
        d = k - last_e;
        if (last_kind == 3 && d >= 1 && d <= np) begin
          exp_err[k] = 1'b1; err_tag[k] = "R7";
        end else if (last_kind == 2 && d >= 1 && d <= np) begin
          exp_err[k] = 1'b1; err_tag[k] = "R8";
          for (int s = k + cl; s < k + cl + 8; s++) if (exp_v[s]) exp_tag[s] = "R8";
        end else if (last_kind == 1 && d >= 1 && d <= np) begin
          clear_from(k + cl, "R6");
        end else begin
          err_tag[k] = "R9";
        end
      end
      default: begin
        if (c > 3'd4)
          for (int s = k + cl; s < k + cl + 2; s++) if (!exp_v[s]) exp_tag[s] = "R1";
      end
    endcase
  endtask

  task automatic step(logic [2:0] c, logic [7:0] a);
    @(negedge clk);
    check_now();
    predict(e + 1, c, a);
    cmd = c;
    col_addr = a;
    @(posedge clk);
    e++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(3'd0, 8'd0);
  endtask

  // R1: a read code present only in the high phase must be ignored
  task automatic glitch();
    @(negedge clk);
    check_now();
    predict(e + 1, 3'd0, 8'd0);
    for (int s = e + 1 + cl; s < e + cl + 6; s++) if (!exp_v[s]) exp_tag[s] = "R1";
    cmd = 3'd0;
    @(posedge clk);
    e++;
    #1 cmd = 3'd1;
    col_addr = 8'h10;
  endtask

  task automatic set_cfg(logic [1:0] bl, logic c);
    idle(12);
    cfg_bl = bl;
    cfg_cl = c;
    np = (bl == 2'd0) ? 1 : (bl == 2'd1) ? 2 : 4;
    cl = c ? 3 : 2;
    last_kind = 0;
  endtask

  task automatic directed();
    step(3'd1, 8'h3C); idle(8);
    step(3'd1, 8'hFE); idle(8);
    for (int d = 1; d <= np + 1; d++) begin
      step(3'd1, 8'(8'h40 + d)); idle(d - 1); step(3'd4, 8'd0); idle(8);
    end
    for (int d = 1; d <= np; d += (np > 1 ? np - 1 : 1)) begin
      step(3'd2, 8'h22); idle(d - 1); step(3'd4, 8'd0); idle(8);
      step(3'd3, 8'h00); idle(d - 1); step(3'd4, 8'd0); idle(8);
    end
    step(3'd4, 8'd0); idle(4);
    for (int d = 1; d <= 2; d++) begin
      step(3'd1, 8'h60); idle(d - 1); step(3'd1, 8'hA0); idle(10);
    end
    step(3'd1, 8'h70); step(3'd3, 8'h00); idle(8);
    step(3'd6, 8'h55); idle(6);
    glitch(); idle(8);
  endtask

  task automatic random_run(int n);
    int r;
    logic [2:0] c;
    for (int i = 0; i < n; i++) begin
      r = int'($urandom % 20);
      if (r < 8) c = 3'd0;
      else if (r < 12) c = 3'd1;
      else if (r < 14) c = 3'd2;
      else if (r < 16) c = 3'd3;
      else if (r < 19) c = 3'd4;
      else c = 3'(5 + $urandom % 3);
      step(c, 8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < SLOTS; s++) begin
      exp_tag[s] = "R2";
      err_tag[s] = "R9";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13
    chk("R13", 64'(data_oe), 64'd0);
    chk("R13", 64'(strobe_oe), 64'd0);
    chk("R13", 64'(stop_err), 64'd0);
    chk("R13", 64'(rd_data_rise | rd_data_fall), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    e = 0;
    for (int cfg = 0; cfg < 8; cfg++) begin
      set_cfg(2'(cfg >> 1), cfg[0]);
      directed();
      random_run(450);
    end
    idle(12);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule